// File: doc/BRIEF.md
# Single-Operand ALU with Condition Flags

This block is the unary arithmetic and logic stage of a 16-bit minicomputer-style datapath. It takes one operand, an operation code and a byte/word select, and it produces the result and the next value of the four condition flags. The result and the next flags are combinational. A four-bit flag register captures the next flags whenever the valid strobe is high.

The carry used by add-carry, subtract-carry and the rotates, and the negative flag used by sign extend, come from the block's own flag register. Flags that an operation leaves unchanged are copied from that register. Flag bits are packed as N in bit 3, Z in bit 2, V in bit 1 and C in bit 0.

Byte mode works on the low eight bits. The upper eight result bits then pass the operand's upper byte through unchanged. Operand fetch, addressing and two-operand operations are handled elsewhere.

Top module: `uop_alu`

## Requirements
- R1: With byteSel=1, every opcode other than 12 and 13 works on operand bits 7:0. Result bits 15:8 equal operand bits 15:8. N is result bit 7, Z is set when result bits 7:0 are zero, and every carry, shift and overflow rule uses bit 7 as the top bit.
- R2: Opcode 0 (clear) gives a zero result and flags N=0, Z=1, V=0, C=0.
- R3: Opcode 1 (complement) inverts the operand. N and Z follow the result, V=0 and C=1.
- R4: Opcode 2 adds one and opcode 3 subtracts one. N and Z follow the result and C is unchanged. V is set only when incrementing the largest positive value or decrementing the most negative value.
- R5: Opcode 4 (negate) gives the two's complement of the operand. V is set only when the operand is the most negative value. C is set unless the result is zero.
- R6: Opcode 5 adds the stored C to the operand and opcode 6 subtracts it. C is the carry out (opcode 5) or the borrow out (opcode 6). V flags a signed overflow. N and Z follow the result.
- R7: Opcode 7 (test) passes the operand through, sets N and Z from it, and clears V and C.
- R8: Opcode 8 rotates right through carry: C enters the top bit and bit 0 goes to C. Opcode 9 rotates left: C enters bit 0 and the top bit goes to C. V equals N XOR C after the rotate.
- R9: Opcode 10 shifts right arithmetically, keeping the sign bit, with bit 0 going to C. Opcode 11 shifts left, inserting zero, with the top bit going to C. V equals N XOR C after the shift.
- R10: Opcode 12 exchanges the two bytes in word form regardless of byteSel. N and Z come from the low byte of the result, and V and C are cleared.
- R11: Opcode 13 writes all ones when the stored N is 1 and all zeros otherwise, regardless of byteSel. Z is set when the result is zero, V is cleared, and N and C are unchanged.
- R12: Opcodes 14 and 15 pass the operand through and leave all four flags unchanged.
- R13: The flag register resets to 0000. It loads the next flags on a clock edge with valid high and holds its value while valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the flag register |
| valid | input | 1 | Load strobe for the flag register |
| opCode | input | 4 | Operation code |
| byteSel | input | 1 | 1 selects byte operation on bits 7:0 |
| operand | input | 16 | Operand |
| result | output | 16 | Combinational result |
| nextFlags | output | 4 | Combinational next flags {N,Z,V,C} |
| flags | output | 4 | Registered flags {N,Z,V,C} |

## Verification
The hardest part to reach from the ports is the stored flag state that feeds the carry-dependent and sign-extend operations. There is no direct way to write the flags; they can only be set by running an operation with valid high. The bench therefore lands on each of the four combinations of stored N and C with a single load:
- clear gives N=0, C=0;
- test of 0x8000 gives N=1, C=0;
- complement of 0x0000 gives N=1, C=1;
- complement of 0xFFFF gives N=0, C=1.

From each of these states it sweeps every opcode over all byte values and a spread of word values, including the overflow corners, with valid held low.

// File: rtl/uop_alu_pkg.sv
package uop_alu_pkg;

  typedef enum logic [3:0] {
    OP_CLR  = 4'd0,  OP_COM  = 4'd1,  OP_INC  = 4'd2,  OP_DEC  = 4'd3,
    OP_NEG  = 4'd4,  OP_ADC  = 4'd5,  OP_SBC  = 4'd6,  OP_TST  = 4'd7,
    OP_ROR  = 4'd8,  OP_ROL  = 4'd9,  OP_ASR  = 4'd10, OP_ASL  = 4'd11,
    OP_SWAB = 4'd12, OP_SXT  = 4'd13, OP_RSVA = 4'd14, OP_RSVB = 4'd15
  } aluOp_e;

  typedef enum logic [1:0] {
    FL_KEEP, FL_CLR, FL_SET, FL_CALC
  } flagRule_e;

  typedef enum logic [3:0] {
    RS_ZERO, RS_INV, RS_INC, RS_DEC, RS_NEG, RS_ADC, RS_SBC, RS_PASS,
    RS_ROR, RS_ROL, RS_ASR, RS_ASL, RS_SWAP, RS_SEXT
  } resSel_e;

  typedef struct packed {
    resSel_e   resSel;
    logic      narrow;
    flagRule_e nRule;
    flagRule_e zRule;
    flagRule_e vRule;
    flagRule_e cRule;
  } aluStrobes_t;

endpackage

// File: rtl/uop_alu_ctrl.sv
module uop_alu_ctrl
  import uop_alu_pkg::*;
(
  input  logic [3:0]  opCode,
  input  logic        byteSel,
  output aluStrobes_t strobes
);

  always_comb begin
    strobes.resSel = RS_PASS;
    strobes.narrow = byteSel;
    strobes.nRule  = FL_CALC;
    strobes.zRule  = FL_CALC;
    strobes.vRule  = FL_CALC;
    strobes.cRule  = FL_CALC;
    case (aluOp_e'(opCode))
      OP_CLR: begin
        strobes.resSel = RS_ZERO;
        strobes.nRule  = FL_CLR;
        strobes.zRule  = FL_SET;
        strobes.vRule  = FL_CLR;
        strobes.cRule  = FL_CLR;
      end
      OP_COM: begin
        strobes.resSel = RS_INV;
        strobes.vRule  = FL_CLR;
        strobes.cRule  = FL_SET;
      end
      OP_INC: begin
        strobes.resSel = RS_INC;
        strobes.cRule  = FL_KEEP;
      end
      OP_DEC: begin
        strobes.resSel = RS_DEC;
        strobes.cRule  = FL_KEEP;
      end
      OP_NEG: strobes.resSel = RS_NEG;
      OP_ADC: strobes.resSel = RS_ADC;
      OP_SBC: strobes.resSel = RS_SBC;
      OP_TST: begin
        strobes.resSel = RS_PASS;
        strobes.vRule  = FL_CLR;
        strobes.cRule  = FL_CLR;
      end
      OP_ROR: strobes.resSel = RS_ROR;
      OP_ROL: strobes.resSel = RS_ROL;
      OP_ASR: strobes.resSel = RS_ASR;
      OP_ASL: strobes.resSel = RS_ASL;
      OP_SWAB: begin
        strobes.resSel = RS_SWAP;
        strobes.narrow = 1'b0;
        strobes.vRule  = FL_CLR;
        strobes.cRule  = FL_CLR;
      end
      OP_SXT: begin
        strobes.resSel = RS_SEXT;
        strobes.narrow = 1'b0;
        strobes.nRule  = FL_KEEP;
        strobes.vRule  = FL_CLR;
        strobes.cRule  = FL_KEEP;
      end
      default: begin
        strobes.resSel = RS_PASS;
        strobes.nRule  = FL_KEEP;
        strobes.zRule  = FL_KEEP;
        strobes.vRule  = FL_KEEP;
        strobes.cRule  = FL_KEEP;
      end
    endcase
  end

endmodule

// File: rtl/uop_alu_core.sv
module uop_alu_core
  import uop_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic         carryIn,
  input  logic         negIn,
  input  resSel_e      resSel,
  output logic [W-1:0] res,
  output logic         calcV,
  output logic         calcC
);

  localparam int HALF = W / 2;
  localparam int TOP  = W - 1;

  logic [W:0] sumExt;
  logic [W:0] diffExt;

  assign sumExt  = {1'b0, a} + {{W{1'b0}}, carryIn};
  assign diffExt = {1'b0, a} - {{W{1'b0}}, carryIn};

  always_comb begin
    res   = a;
    calcV = 1'b0;
    calcC = 1'b0;
    case (resSel)
      RS_ZERO: res = '0;
      RS_INV:  res = ~a;
      RS_INC: begin
        res   = a + W'(1);
        calcV = ~a[TOP] & res[TOP];
      end
      RS_DEC: begin
        res   = a - W'(1);
        calcV = a[TOP] & ~res[TOP];
      end
      RS_NEG: begin
        res   = '0 - a;
        calcV = a[TOP] & res[TOP];
        calcC = |res;
      end
      RS_ADC: begin
        res   = sumExt[TOP:0];
        calcC = sumExt[W];
        calcV = ~a[TOP] & res[TOP];
      end
      RS_SBC: begin
        res   = diffExt[TOP:0];
        calcC = diffExt[W];
        calcV = a[TOP] & ~res[TOP];
      end
      RS_ROR: begin
        res   = {carryIn, a[TOP:1]};
        calcC = a[0];
        calcV = res[TOP] ^ a[0];
      end
      RS_ROL: begin
        res   = {a[TOP-1:0], carryIn};
        calcC = a[TOP];
        calcV = res[TOP] ^ a[TOP];
      end
      RS_ASR: begin
        res   = {a[TOP], a[TOP:1]};
        calcC = a[0];
        calcV = res[TOP] ^ a[0];
      end
      RS_ASL: begin
        res   = {a[TOP-1:0], 1'b0};
        calcC = a[TOP];
        calcV = res[TOP] ^ a[TOP];
      end
      RS_SWAP: res = {a[HALF-1:0], a[TOP:HALF]};
      RS_SEXT: res = {W{negIn}};
      default: res = a;
    endcase
  end

endmodule

// File: rtl/uop_alu_dp.sv
module uop_alu_dp
  import uop_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic [WIDTH-1:0] operand,
  input  aluStrobes_t      strobes,
  output logic [WIDTH-1:0] result,
  output logic [3:0]       nextFlags,
  output logic [3:0]       flags
);

  localparam int HALF = WIDTH / 2;
  localparam int MSB  = WIDTH - 1;
  localparam int BMSB = HALF - 1;
  localparam int FN = 3, FZ = 2, FV = 1, FC = 0;

  logic [MSB:0]  wideRes;
  logic [BMSB:0] byteRes;
  logic          wideV, wideC, byteV, byteC;
  logic          calcN, calcZ, calcV, calcC;

  uop_alu_core #(.W(WIDTH)) u_wide (
    .a(operand), .carryIn(flags[FC]), .negIn(flags[FN]), .resSel(strobes.resSel),
    .res(wideRes), .calcV(wideV), .calcC(wideC)
  );

  uop_alu_core #(.W(HALF)) u_byte (
    .a(operand[BMSB:0]), .carryIn(flags[FC]), .negIn(flags[FN]), .resSel(strobes.resSel),
    .res(byteRes), .calcV(byteV), .calcC(byteC)
  );

  function automatic logic pickFlag(flagRule_e rule, logic oldVal, logic calcVal);
    case (rule)
      FL_KEEP: return oldVal;
      FL_CLR:  return 1'b0;
      FL_SET:  return 1'b1;
      default: return calcVal;
    endcase
  endfunction

  always_comb begin
    if (strobes.narrow) begin
      result = {operand[MSB:HALF], byteRes};
      calcN  = byteRes[BMSB];
      calcZ  = (byteRes == '0);
      calcV  = byteV;
      calcC  = byteC;
    end else begin
      result = wideRes;
      calcV  = wideV;
      calcC  = wideC;
      if (strobes.resSel == RS_SWAP) begin
        calcN = wideRes[BMSB];
        calcZ = (wideRes[BMSB:0] == '0);
      end else begin
        calcN = wideRes[MSB];
        calcZ = (wideRes == '0);
      end
    end
    nextFlags[FN] = pickFlag(strobes.nRule, flags[FN], calcN);
    nextFlags[FZ] = pickFlag(strobes.zRule, flags[FZ], calcZ);
    nextFlags[FV] = pickFlag(strobes.vRule, flags[FV], calcV);
    nextFlags[FC] = pickFlag(strobes.cRule, flags[FC], calcC);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     flags <= 4'b0000;
    else if (valid) flags <= nextFlags;
  end

  a_r13_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> $stable(flags));

  a_r13_load_next: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> flags == $past(nextFlags));

  a_r2_clear_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && strobes.resSel == RS_ZERO) |=> flags == 4'b0100);

  a_r3_com_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && strobes.resSel == RS_INV) |=> flags[FC] && !flags[FV]);

  a_r4_incdec_keep_c: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && (strobes.resSel == RS_INC || strobes.resSel == RS_DEC))
      |=> flags[FC] == $past(flags[FC]));

  a_r11_sext_keep_n: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && strobes.resSel == RS_SEXT)
      |=> flags[FN] == $past(flags[FN]) && flags[FZ] != flags[FN]);

endmodule

// File: rtl/uop_alu.sv
module uop_alu
  import uop_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic [3:0]       opCode,
  input  logic             byteSel,
  input  logic [WIDTH-1:0] operand,
  output logic [WIDTH-1:0] result,
  output logic [3:0]       nextFlags,
  output logic [3:0]       flags
);

  aluStrobes_t strobes;

  uop_alu_ctrl u_ctrl (
    .opCode(opCode), .byteSel(byteSel), .strobes(strobes)
  );

  uop_alu_dp #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .valid(valid), .operand(operand),
    .strobes(strobes), .result(result), .nextFlags(nextFlags), .flags(flags)
  );

endmodule

// File: tb/uop_alu_test.sv
`timescale 1ns/1ps
module uop_alu_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [3:0]  opCode = 4'd0;
  logic        byteSel = 1'b0;
  logic [15:0] operand = 16'h0;
  logic [15:0] result;
  logic [3:0]  nextFlags;
  logic [3:0]  flags;

  int checks = 0;
  int fails  = 0;
  logic [3:0] expFlags = 4'b0000;

  always #5 clk = ~clk;

  uop_alu uut (
    .clk(clk), .rst_n(rst_n), .valid(valid), .opCode(opCode), .byteSel(byteSel),
    .operand(operand), .result(result), .nextFlags(nextFlags), .flags(flags)
  );

  function automatic string reqOf(int op, bit bm);
    string t;
    case (op)
      0: t = "R2";  1: t = "R3";  2, 3: t = "R4";  4: t = "R5";
      5, 6: t = "R6"; 7: t = "R7"; 8, 9: t = "R8"; 10, 11: t = "R9";
      12: t = "R10"; 13: t = "R11"; default: t = "R12";
    endcase
    if (bm && op < 12) t = {"R1+", t};
    return t;
  endfunction

  // returns {flags, result}; flags packed N,Z,V,C
  function automatic logic [19:0] model(int op, bit bm, logic [15:0] a, logic [3:0] f);
    int w, mask, top, x, r, s;
    bit n, z, v, c, cin;
    w = (bm && op != 12 && op != 13) ? 8 : 16;
    mask = (1 << w) - 1;
    top = 1 << (w - 1);
    x = int'(a) & mask;
    n = f[3]; z = f[2]; v = f[1]; c = f[0];
    cin = f[0];
    r = x;
    case (op)
      0: begin r = 0; n = 0; z = 1; v = 0; c = 0; end
      1: begin r = ~x & mask; v = 0; c = 1; end
      2: begin r = (x + 1) & mask; v = (x == top - 1); end
      3: begin r = (x - 1) & mask; v = (x == top); end
      4: begin r = (-x) & mask; v = (x == top); c = (r != 0); end
      5: begin s = x + cin; r = s & mask; c = (s > mask); v = (x == top - 1) && cin; end
      6: begin s = x - cin; r = s & mask; c = (s < 0); v = (x == top) && cin; end
      7: begin r = x; v = 0; c = 0; end
      8: begin r = (x >> 1) | (cin ? top : 0); c = x[0]; end
      9: begin r = ((x << 1) & mask) | cin; c = ((x & top) != 0); end
      10: begin r = (x >> 1) | (x & top); c = x[0]; end
      11: begin r = (x << 1) & mask; c = ((x & top) != 0); end
      12: begin r = ((x & 255) << 8) | (x >> 8); end
      13: begin r = f[3] ? 65535 : 0; end
      default: r = x;
    endcase
    if (op >= 1 && op <= 11) begin
      n = ((r & top) != 0);
      z = (r == 0);
    end
    if (op >= 8 && op <= 11) v = n ^ c;
    if (op == 12) begin
      n = ((r & 128) != 0); z = ((r & 255) == 0); v = 0; c = 0;
    end
    if (op == 13) begin
      z = !f[3]; v = 0;
    end
    if (w == 8) r = (int'(a) & 16'hFF00) | r;
    return {n, z, v, c, r[15:0]};
  endfunction

  task automatic check(bit ok, string req, logic [19:0] act, logic [19:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual flags=%b result=%h, expected flags=%b result=%h",
               req, act[19:16], act[15:0], exp[19:16], exp[15:0]);
    end
  endtask

  task automatic combCheck(int op, bit bm, logic [15:0] a);
    logic [19:0] e;
    opCode = op[3:0]; byteSel = bm; operand = a;
    #1;
    e = model(op, bm, a, expFlags);
    check({nextFlags, result} === e, reqOf(op, bm), {nextFlags, result}, e);
  endtask

  task automatic doLoad(int op, bit bm, logic [15:0] a);
    logic [19:0] e;
    @(negedge clk);
    opCode = op[3:0]; byteSel = bm; operand = a; valid = 1'b1;
    e = model(op, bm, a, expFlags);
    @(posedge clk);
    #1 valid = 1'b0;
    expFlags = e[19:16];
    check(flags === expFlags, {"R13 load ", reqOf(op, bm)}, {flags, 16'h0}, {expFlags, 16'h0});
  endtask

  task automatic sweepAll();
    logic [15:0] corners [8] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000,
                                 16'hFFFF, 16'h00FF, 16'hFF00, 16'h007F};
    for (int op = 0; op < 16; op++) begin
      for (int x = 0; x < 256; x++)
        combCheck(op, 1'b1, {8'((x * 37) & 255), 8'(x)});
      for (int k = 0; k < 1024; k++)
        combCheck(op, 1'b0, 16'((k * 64) | ((k * 7) & 63)));
      for (int i = 0; i < 8; i++) begin
        combCheck(op, 1'b0, corners[i]);
        combCheck(op, 1'b1, corners[i]);
      end
    end
    #1;
    check(flags === expFlags, "R13 hold while idle", {flags, 16'h0}, {expFlags, 16'h0});
  endtask

  initial begin
    #1_500_000;
    checks++; fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    check(flags === 4'b0000, "R13 reset", {flags, 16'h0}, 20'h0);

    // stored N=0,C=0 via clear
    doLoad(0, 1'b0, 16'h1234);
    sweepAll();
    // stored N=1,C=0 via test of most negative
    doLoad(7, 1'b0, 16'h8000);
    sweepAll();
    // stored N=1,C=1 via complement of zero
    doLoad(1, 1'b0, 16'h0000);
    sweepAll();
    // stored N=0,C=1 via complement of all ones
    doLoad(1, 1'b0, 16'hFFFF);
    sweepAll();

    // a chain of loads with carry-dependent operations
    doLoad(5, 1'b0, 16'hFFFF);
    doLoad(8, 1'b0, 16'h0002);
    doLoad(6, 1'b1, 16'hAB00);
    doLoad(13, 1'b1, 16'h5555);
    doLoad(14, 1'b0, 16'h0000);
    doLoad(4, 1'b0, 16'h8000);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule